// File: doc/BRIEF.md
# Dual-Destination Interrupt Event Router

This block sits beside an image-statistics engine and turns its single-cycle event pulses (start of frame, end of frame, and similar) into interrupt requests for two processors. Every pulse is caught in a sticky status bit. Each event has an enable bit and a destination bit. The destination bit sends the event either to the host processor line or to the signal processor line. Both interrupt outputs are level signals. Each stays high while any enabled, pending event is routed to it.

Status is captured whether or not the event is enabled. Software that prefers polling can therefore leave all enables at zero and read the status word. Software clears a status bit by writing a one to it. A small word-wide register port gives access to the status, enable and destination words. Its read data is combinational from the presented address.

Top module: `evt_irq_router`

## Requirements
- R1: After reset the status, enable and destination words all read 0, and both `irq_host` and `irq_sigp` are low.
- R2: A high `evt_pulse[i]` at a clock edge sets status bit i at that edge. The bit stays set until software clears it, whatever the value of enable bit i.
- R3: A write to address 0 (status) clears every status bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R4: When an event pulse and a status clear hit the same bit at the same edge, the bit ends up set.
- R5: `irq_host` is high exactly when some bit i has status=1, enable=1 and destination bit=0. `irq_sigp` is high exactly when some bit i has status=1, enable=1 and destination bit=1.
- R6: A pending status bit whose enable bit is 0 drives neither interrupt output.
- R7: A write to address 1 (enable) or address 2 (destination) changes the interrupt outputs in the cycle after the write edge, and leaves the status word unchanged.
- R8: Address 3 reads as 0. Writes to address 3 change no register.
- R9: Reads of addresses 1 and 2 return the last value written there. The read data follows `cfg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_pulse | input | N_EVT | One-cycle event pulses, one bit per event |
| cfg_wr | input | 1 | Write strobe for the register port |
| cfg_addr | input | 2 | Word address: 0 status, 1 enable, 2 destination, 3 spare |
| cfg_wdata | input | N_EVT | Write data |
| cfg_rdata | output | N_EVT | Read data for `cfg_addr`, combinational |
| irq_host | output | 1 | Level interrupt to the host processor |
| irq_sigp | output | 1 | Level interrupt to the signal processor |

## Verification
The bench builds the router with N_EVT = 5. This width is not a power of two, so any mask or slicing that assumes a full byte shows up at once. With only five events, the constrained random stream often leaves one destination with no enabled pending bit. The same stream often lands event pulses and write-one clears on the same bit in the same cycle. Both interrupt levels are therefore seen rising and falling many times, and the event-versus-clear collision is hit repeatedly. Directed steps before the random phase cover the reset state, polling with enables off, switching the destination, and the spare address.

// File: rtl/evr_pkg.sv
package evr_pkg;

  typedef enum logic [1:0] {
    EVR_A_STATUS = 2'd0,
    EVR_A_ENABLE = 2'd1,
    EVR_A_DEST   = 2'd2,
    EVR_A_SPARE  = 2'd3
  } evr_addr_e;

  localparam int EVR_N_DST    = 2;
  localparam int EVR_DST_HOST = 0;
  localparam int EVR_DST_SIGP = 1;

endpackage

// File: rtl/evr_cfg_regs.sv
module evr_cfg_regs
  import evr_pkg::*;
#(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [N_EVT-1:0] wdata,
  output logic [N_EVT-1:0] en_q,
  output logic [N_EVT-1:0] dest_q
);

  logic             en_ce;
  logic             dest_ce;
  logic [N_EVT-1:0] en_d;
  logic [N_EVT-1:0] dest_d;

  always_comb begin
    en_ce   = wr && (addr == EVR_A_ENABLE);
    dest_ce = wr && (addr == EVR_A_DEST);
    en_d    = wdata;
    dest_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
    end else if (dest_ce) begin
      dest_q <= dest_d;
    end
  end

  // R8: the spare address leaves both words untouched
  a_r8_spare_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == EVR_A_SPARE) |=> ($stable(en_q) && $stable(dest_q)));

  // R9: a write to the enable word lands on the next edge
  a_r9_enable_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == EVR_A_ENABLE) |=> (en_q == $past(wdata)));

endmodule

// File: rtl/evr_sticky_status.sv
module evr_sticky_status #(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt,
  input  logic             clr_en,
  input  logic [N_EVT-1:0] clr_mask,
  output logic [N_EVT-1:0] status_q
);

  logic [N_EVT-1:0] clr_eff;
  logic [N_EVT-1:0] status_d;
  logic             status_ce;

  always_comb begin
    clr_eff   = clr_en ? clr_mask : '0;
    status_ce = clr_en || (|evt);
    status_d  = (status_q & ~clr_eff) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_ce) begin
      status_q <= status_d;
    end
  end

  // R2 / R4: every pulsed bit is set after the edge, even under a clear
  a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt)));

  // R3: a cleared bit with no event falls
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && (|(clr_mask & ~evt))) |=> ((status_q & $past(clr_mask & ~evt)) == '0));

  // R3: bits neither pulsed nor cleared hold their value
  a_r3_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(clr_eff | evt)) == ($past(status_q) & ~$past(clr_eff | evt))));

endmodule

// File: rtl/evr_irq_merge.sv
module evr_irq_merge
  import evr_pkg::*;
#(
  parameter int N_EVT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_EVT-1:0]     status,
  input  logic [N_EVT-1:0]     en,
  input  logic [N_EVT-1:0]     dest,
  output logic [EVR_N_DST-1:0] irq
);

  logic [N_EVT-1:0] armed;

  always_comb armed = status & en;

  for (genvar d = 0; d < EVR_N_DST; d++) begin : g_dst
    logic [N_EVT-1:0] sel;
    always_comb begin
      sel    = (d == EVR_DST_SIGP) ? dest : ~dest;
      irq[d] = |(armed & sel);
    end
  end

  // R6: nothing enabled and pending means both lines are quiet
  a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & en) == '0) |-> (irq == '0));

  // R5: at most one destination per pending bit, so with one armed bit only one line rises
  a_r5_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(status & en) == 1) |-> $onehot(irq));

endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
  import evr_pkg::*;
#(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [N_EVT-1:0] cfg_wdata,
  output logic [N_EVT-1:0] cfg_rdata,
  output logic             irq_host,
  output logic             irq_sigp
);

  logic [1:0]           rst_pipe;
  logic                 rst_sync_n;
  logic [N_EVT-1:0]     status;
  logic [N_EVT-1:0]     en;
  logic [N_EVT-1:0]     dest;
  logic                 clr_en;
  logic [EVR_N_DST-1:0] irq;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  always_comb rst_sync_n = rst_pipe[1];

  always_comb clr_en = cfg_wr && (cfg_addr == EVR_A_STATUS);

  evr_cfg_regs #(.N_EVT(N_EVT)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr     (cfg_wr),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .en_q   (en),
    .dest_q (dest)
  );

  evr_sticky_status #(.N_EVT(N_EVT)) u_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt      (evt_pulse),
    .clr_en   (clr_en),
    .clr_mask (cfg_wdata),
    .status_q (status)
  );

  evr_irq_merge #(.N_EVT(N_EVT)) u_merge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .status (status),
    .en     (en),
    .dest   (dest),
    .irq    (irq)
  );

  always_comb begin
    irq_host = irq[EVR_DST_HOST];
    irq_sigp = irq[EVR_DST_SIGP];
    unique case (cfg_addr)
      EVR_A_STATUS: cfg_rdata = status;
      EVR_A_ENABLE: cfg_rdata = en;
      EVR_A_DEST:   cfg_rdata = dest;
      default:      cfg_rdata = '0;
    endcase
  end

  // R7: a config write never disturbs pending status when no event or clear coincides
  a_r7_status_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_wr && cfg_addr != EVR_A_STATUS && evt_pulse == '0) |=> $stable(status));

endmodule

// File: tb/evt_irq_router_test.sv
module evt_irq_router_test;

  localparam int NE = 5;

  logic          clk;
  logic          rst_n;
  logic [NE-1:0] evt_pulse;
  logic          cfg_wr;
  logic [1:0]    cfg_addr;
  logic [NE-1:0] cfg_wdata;
  logic [NE-1:0] cfg_rdata;
  logic          irq_host;
  logic          irq_sigp;

  int vectors;
  int miscompares;
  bit done;

  logic [NE-1:0] m_st;
  logic [NE-1:0] m_en;
  logic [NE-1:0] m_dst;

  evt_irq_router #(.N_EVT(NE)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .irq_host  (irq_host),
    .irq_sigp  (irq_sigp)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic f_irq(input logic [NE-1:0] st, input logic [NE-1:0] en,
                                 input logic [NE-1:0] dst, input bit to_sigp);
    return |(st & en & (to_sigp ? dst : ~dst));
  endfunction

  function automatic logic [NE-1:0] f_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_st;
      2'd1:    return m_en;
      2'd2:    return m_dst;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [NE-1:0] act, input logic [NE-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive, update model at the edge, check the outputs after it
  task automatic step(input string tag, input logic [NE-1:0] ev, input logic wr,
                      input logic [1:0] a, input logic [NE-1:0] wd);
    logic [NE-1:0] clr;
    evt_pulse = ev; cfg_wr = wr; cfg_addr = a; cfg_wdata = wd;
    @(posedge clk);
    clr = (wr && a == 2'd0) ? wd : '0;
    m_st = (m_st & ~clr) | ev;
    if (wr && a == 2'd1) m_en = wd;
    if (wr && a == 2'd2) m_dst = wd;
    #2;
    evt_pulse = '0; cfg_wr = 1'b0;
    chk({tag, " irq_host"}, NE'(irq_host), NE'(f_irq(m_st, m_en, m_dst, 1'b0)));
    chk({tag, " irq_sigp"}, NE'(irq_sigp), NE'(f_irq(m_st, m_en, m_dst, 1'b1)));
  endtask

  task automatic rd(input string tag, input logic [1:0] a);
    cfg_wr = 1'b0; evt_pulse = '0; cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, f_read(a));
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 4; a++) rd(tag, 2'(a));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    vectors = 0; miscompares = 0; done = 0;
    m_st = '0; m_en = '0; m_dst = '0;
    evt_pulse = '0; cfg_wr = 1'b0; cfg_addr = 2'd0; cfg_wdata = '0;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;

    // R1 reset state
    rd_all("R1 reset read");
    chk("R1 irq_host reset", NE'(irq_host), '0);
    chk("R1 irq_sigp reset", NE'(irq_sigp), '0);

    // R2, R6: event with enables off is latched but silent
    step("R6 disabled event", 5'b00001, 1'b0, 2'd0, '0);
    rd("R2 status polled", 2'd0);
    step("R2 sticky idle", '0, 1'b0, 2'd0, '0);

    // R7, R5: enable bit 0, host line next cycle
    step("R7 enable host", '0, 1'b1, 2'd1, 5'b00001);
    chk("R5 host asserted", NE'(irq_host), NE'(1));
    // R7: swap destination, status kept
    step("R7 route to sigp", '0, 1'b1, 2'd2, 5'b00001);
    chk("R5 sigp asserted", NE'(irq_sigp), NE'(1));
    rd("R7 status kept", 2'd0);
    rd_all("R9 readback");

    // R3: zeros leave status, ones clear
    step("R3 write zeros", '0, 1'b1, 2'd0, 5'b00000);
    rd("R3 unchanged", 2'd0);
    step("R3 write one", '0, 1'b1, 2'd0, 5'b00001);
    rd("R3 cleared", 2'd0);

    // R4: event and clear on bit 2 in one cycle
    step("R4 setup", 5'b00100, 1'b0, 2'd0, '0);
    step("R4 collide", 5'b00100, 1'b1, 2'd0, 5'b00100);
    rd("R4 event wins", 2'd0);

    // R8: spare address
    step("R8 spare write", '0, 1'b1, 2'd3, 5'b11111);
    rd_all("R8 spare ignored");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [NE-1:0] ev;
      logic          wr;
      logic [1:0]    a;
      logic [NE-1:0] wd;
      ev = ($urandom_range(0, 3) == 0) ? NE'($urandom) & NE'($urandom) : '0;
      wr = ($urandom_range(0, 2) == 0);
      a  = 2'($urandom);
      wd = NE'($urandom);
      step("R5 random", ev, wr, a, wd);
      if (n % 4 == 0) rd_all("R9 random read");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule